// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block is the loop divider of a frequency synthesizer. It runs on a clock taken from the VCO and divides it in two stages. The first stage is a prescaler whose modulus depends on a band select: 8 for the AM band and 64 for the FM band. The second stage is a 14-bit programmable counter. For a program value N it divides the prescaler ticks by N+1. Each complete division cycle produces one single-cycle pulse, and that pulse goes to the phase comparator.

The program value and the band are sampled only at the terminal count. Software can therefore rewrite them at any time without breaking a cycle that is already running. The same terminal event reloads the counter and restarts the prescaler.

A small direction detector sits behind the divider. It compares the divided pulse with a reference tick and tells the charge pump which way to push. If the divided pulse arrives first, the VCO is fast and the detector asks for current sourcing. If the reference arrives first, the VCO is slow and the detector asks for current sinking.

Top module: `loop_divider`

## Requirements
- R1: During reset `div_out`, `pump_src` and `pump_snk` are low. The terminal state of reset is counter 0 with the AM band active, so the first `div_out` pulse appears AM_DIV clocks after reset is released. That pulse latches the first program value and band.
- R2: For a loaded program value N, the interval between consecutive `div_out` pulses is M*(N+1) clocks, where M is the active prescaler modulus.
- R3: `band_sel`=1 selects the FM modulus (FM_DIV, default 64) and `band_sel`=0 selects the AM modulus (AM_DIV, default 8).
- R4: N=0 makes the programmable stage divide by 1, so the output period equals the prescaler modulus.
- R5: The largest value, N=16383, gives a period of M*16384 clocks on both bands.
- R6: `n_in` and `band_sel` are sampled only in the cycle that produces a `div_out` pulse. Changes at any other time do not alter the period in progress.
- R7: Every `div_out` pulse lasts exactly one clock.
- R8: A `div_out` pulse with no pending reference raises `pump_src` in the next cycle. `pump_src` holds until a `ref_tick` arrives and drops in the cycle after it.
- R9: A `ref_tick` with no pending divided pulse raises `pump_snk` in the next cycle. `pump_snk` holds until a `div_out` pulse arrives and drops in the cycle after it.
- R10: When `div_out` and `ref_tick` are high in the same cycle, neither pump output is raised. `pump_src` and `pump_snk` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| n_in | input | 14 | Program value N, total programmable divide N+1 |
| band_sel | input | 1 | Band select: 1 = FM modulus, 0 = AM modulus |
| ref_tick | input | 1 | Single-cycle reference event |
| div_out | output | 1 | Registered single-cycle pulse per division cycle |
| pump_src | output | 1 | VCO fast: request current sourcing |
| pump_snk | output | 1 | VCO slow: request current sinking |

## Verification
The main stimulus is a chain of program values: N of 0, 1 and 100 on each band, then seeded random values with random bands. The default instance runs that chain. A second instance with scaled-down moduli runs N=16383 on both bands, so that the largest count fits the run length. Each next setting is driven just after a pulse, while the previous period is still running. A period that comes out wrong therefore shows one of three faults: the modulus for that band is wrong, the counter is off by one around N+1, or the inputs are picked up in the middle of a cycle. The direction detector is driven three ways: with the reference alone, with the divided pulse alone, and with both in the same cycle. These separate the set, hold, clear and coincidence behaviour of the two pump outputs.

// File: rtl/loop_div_pkg.sv
package loop_div_pkg;

  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;

  // Prescaler modulus for a given band
  function automatic int unsigned band_modulus(band_e b, int unsigned am_div,
                                               int unsigned fm_div);
    return (b == BAND_FM) ? fm_div : am_div;
  endfunction

endpackage

// File: rtl/loop_div_prescaler.sv
module loop_div_prescaler
  import loop_div_pkg::*;
#(
  parameter int unsigned AM_DIV = 8,
  parameter int unsigned FM_DIV = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  band_e band,
  output logic  tick
);

  localparam int unsigned MAXDIV = (FM_DIV > AM_DIV) ? FM_DIV : AM_DIV;
  localparam int unsigned PW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] last;

  assign last = PW'(band_modulus(band, AM_DIV, FM_DIV) - 1);
  assign tick = (pcnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
    end else if (tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // The band only changes on a wrap, so the count never passes the active limit
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= last);

  // A band change lines up with a restart of the prescaler
  a_r6_band_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (band != $past(band)) |-> (pcnt_q == '0));

endmodule

// File: rtl/loop_div_counter.sv
module loop_div_counter
  import loop_div_pkg::*;
#(
  parameter int unsigned NW      = 14,
  parameter int unsigned MIN_MOD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [NW-1:0] n_in,
  input  logic          band_in,
  output band_e         band_q,
  output logic          pulse_q
);

  logic [NW-1:0] cnt_q;
  logic          term;

  assign term = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      band_q  <= BAND_AM;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= term;
      if (term) begin
        cnt_q  <= n_in;
        band_q <= band_e'(band_in);
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // Between prescaler ticks the program counter holds
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // Band only moves together with an output pulse
  a_r6_band_only_at_term: assert property (@(posedge clk) disable iff (rst)
    !pulse_q |-> $stable(band_q));

  generate
    if (MIN_MOD > 1) begin : g_width_chk
      a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
    end
  endgenerate

endmodule

// File: rtl/loop_div_dirflag.sv
module loop_div_dirflag (
  input  logic clk,
  input  logic rst,
  input  logic div_ev,
  input  logic ref_ev,
  output logic src_q,
  output logic snk_q
);

  logic src_d;
  logic snk_d;

  always_comb begin
    src_d = src_q | div_ev;
    snk_d = snk_q | ref_ev;
    if (src_d && snk_d) begin
      src_d = 1'b0;
      snk_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      snk_q <= 1'b0;
    end else begin
      src_q <= src_d;
      snk_q <= snk_d;
    end
  end

  a_r10_never_both: assert property (@(posedge clk) disable iff (rst)
    !(src_q && snk_q));

  a_r8_src_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(src_q) |-> $past(div_ev));

  a_r9_snk_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(snk_q) |-> $past(ref_ev));

  a_r10_coincident: assert property (@(posedge clk) disable iff (rst)
    (div_ev && ref_ev) |=> (!src_q && !snk_q));

endmodule

// File: rtl/loop_divider.sv
module loop_divider
  import loop_div_pkg::*;
#(
  parameter int unsigned NW     = 14,
  parameter int unsigned AM_DIV = 8,
  parameter int unsigned FM_DIV = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_in,
  input  logic          band_sel,
  input  logic          ref_tick,
  output logic          div_out,
  output logic          pump_src,
  output logic          pump_snk
);

  localparam int unsigned MIN_MOD = (AM_DIV < FM_DIV) ? AM_DIV : FM_DIV;

  band_e active_band;
  logic  pre_tick;

  loop_div_prescaler #(
    .AM_DIV(AM_DIV),
    .FM_DIV(FM_DIV)
  ) u_pre (
    .clk (clk),
    .rst (rst),
    .band(active_band),
    .tick(pre_tick)
  );

  loop_div_counter #(
    .NW     (NW),
    .MIN_MOD(MIN_MOD)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (pre_tick),
    .n_in   (n_in),
    .band_in(band_sel),
    .band_q (active_band),
    .pulse_q(div_out)
  );

  loop_div_dirflag u_dir (
    .clk   (clk),
    .rst   (rst),
    .div_ev(div_out),
    .ref_ev(ref_tick),
    .src_q (pump_src),
    .snk_q (pump_snk)
  );

  // A divided pulse is always preceded by a prescaler terminal tick
  a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> $past(pre_tick));

endmodule

// File: tb/loop_divider_bench.sv
`timescale 1ns/1ps
module loop_divider_bench;

  localparam int NCASE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [13:0] n_in  [2];
  logic        band  [2];
  logic        ref_t [2];
  logic        divo  [2];
  logic        src   [2];
  logic        snk   [2];

  int am_of [2];
  int fm_of [2];

  int   cn   [2][NCASE];
  bit   cb   [2][NCASE];
  string ctag [2][NCASE];
  int   ccount [2];

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  loop_divider u_loop_divider (
    .clk(clk), .rst(rst), .n_in(n_in[0]), .band_sel(band[0]),
    .ref_tick(ref_t[0]), .div_out(divo[0]), .pump_src(src[0]), .pump_snk(snk[0])
  );

  loop_divider #(.AM_DIV(2), .FM_DIV(4)) u_loop_divider_fast (
    .clk(clk), .rst(rst), .n_in(n_in[1]), .band_sel(band[1]),
    .ref_tick(ref_t[1]), .div_out(divo[1]), .pump_src(src[1]), .pump_snk(snk[1])
  );

  function automatic int exp_period(int n, bit b, int am, int fm);
    return (b ? fm : am) * (n + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count clocks to the next pulse; drive the next setting right after the last pulse
  task automatic measure(int i, int exp, int nn, bit nb, string req);
    int cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        check(divo[i] == 1'b0, "R7 pulse width", int'(divo[i]), 0);
        n_in[i] = 14'(nn);
        band[i] = nb;
      end
    end while (!divo[i] && !done);
    check(cnt == exp, req, cnt, exp);
  endtask

  task automatic run_chain(int i);
    n_in[i] = 14'(cn[i][0]);
    band[i] = cb[i][0];
    @(negedge clk);
    rst = 1'b0;
    measure(i, am_of[i], cn[i][0], cb[i][0], "R1 first pulse");
    for (int k = 0; k < ccount[i]; k++) begin
      int nk = (k + 1 < ccount[i]) ? k + 1 : k;
      measure(i, exp_period(cn[i][k], cb[i][k], am_of[i], fm_of[i]),
              cn[i][nk], cb[i][nk], ctag[i][k]);
    end
  endtask

  task automatic wait_pulse(int i);
    do @(negedge clk); while (!divo[i] && !done);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    am_of[0] = 8; fm_of[0] = 64;
    am_of[1] = 2; fm_of[1] = 4;
    for (int i = 0; i < 2; i++) begin
      n_in[i] = '0; band[i] = 1'b0; ref_t[i] = 1'b0;
    end
    // Directed cases, default moduli
    cn[0][0] = 0;   cb[0][0] = 0; ctag[0][0] = "R4 N=0 AM";
    cn[0][1] = 0;   cb[0][1] = 1; ctag[0][1] = "R4 N=0 FM";
    cn[0][2] = 1;   cb[0][2] = 0; ctag[0][2] = "R2 N=1 AM";
    cn[0][3] = 1;   cb[0][3] = 1; ctag[0][3] = "R3 N=1 FM";
    cn[0][4] = 100; cb[0][4] = 1; ctag[0][4] = "R3 N=100 FM";
    cn[0][5] = 100; cb[0][5] = 0; ctag[0][5] = "R6 N=100 AM after FM";
    for (int k = 6; k < 12; k++) begin
      cn[0][k] = int'($urandom % 200);
      cb[0][k] = 1'($urandom % 2);
      ctag[0][k] = "R2 random";
    end
    cn[0][12] = 100; cb[0][12] = 0; ctag[0][12] = "R2 N=100 AM";
    ccount[0] = 13;
    // Largest count on scaled moduli
    cn[1][0] = 16383; cb[1][0] = 0; ctag[1][0] = "R5 N=16383 AM";
    cn[1][1] = 16383; cb[1][1] = 1; ctag[1][1] = "R5 N=16383 FM";
    cn[1][2] = 0;     cb[1][2] = 1; ctag[1][2] = "R4 N=0 FM fast";
    ccount[1] = 3;

    repeat (3) @(negedge clk);
    check(divo[0] == 0 && src[0] == 0 && snk[0] == 0, "R1 reset outputs",
          int'({divo[0], src[0], snk[0]}), 0);

    fork
      run_chain(0);
      run_chain(1);
    join

    // Direction detector on the default instance, period 808
    wait_pulse(0);
    repeat (2) @(negedge clk);
    ref_t[0] = 1'b1; @(negedge clk); ref_t[0] = 1'b0;
    @(negedge clk);
    check(src[0] == 0 && snk[0] == 0, "R8 src cleared by ref",
          int'({src[0], snk[0]}), 0);
    ref_t[0] = 1'b1; @(negedge clk); ref_t[0] = 1'b0;
    check(snk[0] == 1 && src[0] == 0, "R9 snk set", int'({src[0], snk[0]}), 1);
    repeat (10) @(negedge clk);
    check(snk[0] == 1 && src[0] == 0, "R9 snk held", int'({src[0], snk[0]}), 1);
    wait_pulse(0);
    @(negedge clk);
    check(src[0] == 0 && snk[0] == 0, "R9 snk cleared by div",
          int'({src[0], snk[0]}), 0);
    wait_pulse(0);
    @(negedge clk);
    check(src[0] == 1 && snk[0] == 0, "R8 src set", int'({src[0], snk[0]}), 2);
    ref_t[0] = 1'b1; @(negedge clk); ref_t[0] = 1'b0;
    check(src[0] == 0 && snk[0] == 0, "R8 src cleared", int'({src[0], snk[0]}), 0);
    wait_pulse(0);
    ref_t[0] = 1'b1; @(negedge clk); ref_t[0] = 1'b0;
    check(src[0] == 0 && snk[0] == 0, "R10 coincident", int'({src[0], snk[0]}), 0);
    @(negedge clk);
    check(src[0] == 0 && snk[0] == 0, "R10 stays idle", int'({src[0], snk[0]}), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule